// File: doc/BRIEF.md
# Segment Lookaside Buffer

A small, fully associative table that maps effective-address segments to virtual-segment descriptors. Every slot holds two 64-bit words. The segment word carries the effective segment ID in bits [63:28] and a valid flag in bit 27. The descriptor word carries a two-bit size code in bits [63:62], followed by key and attribute fields that are stored but not decoded here.

A translation front end presents an effective address on the lookup port and gets back, in the same cycle, a hit flag, the slot number and both words of the winning entry. Software-driven maintenance uses the other interfaces:
- a checked write port;
- a registered read port for either word of a slot;
- a command that invalidates every slot except slot 0;
- a command that invalidates the one entry an address maps to.

Both invalidate commands pulse a flush output when they actually remove a valid entry, so that downstream translation caches can drop stale results.

Top module: `seg_lookaside_buf`

## Requirements
- R1: After synchronous reset every word of every slot is zero. No address hits, reads return zero, and `err_pulse` and `flush_pulse` are low.
- R2: Lookup is combinational and forms two keys. The small-segment key is the address with bits [27:0] cleared and bit 27 set. The large-segment key is the address with bits [39:0] cleared and bit 27 set. A slot matches when its segment word equals the small key and its size code is 00 (256 MB), or when it equals the large key and its size code is 01 (1 TB). On a miss, `lk_slot`, `lk_seg_word` and `lk_virt_word` are zero.
- R3: When more than one slot matches, the lowest-numbered slot is reported.
- R4: The slot number is the low 12 bits of `wr_sel_word`. An accepted write takes effect at the next clock edge. It stores `wr_sel_word` with bits [26:0] forced to zero as the segment word, and stores `wr_virt_word` unchanged.
- R5: A write is rejected when any bit of the 12-bit slot field at or above log2(N) is set. A rejected write leaves the table unchanged and raises `err_pulse` for one cycle after the request.
- R6: A write is rejected when descriptor bit 63 is set (size codes 10 and 11). It is also rejected when the size code is 01 while `cfg_big_seg_en` is low.
- R7: A read returns the segment word (`rd_virt_half`=0) or the descriptor word (`rd_virt_half`=1) of slot `rd_idx` on `rd_data` in the cycle after the request. An index of N or more returns zero and raises `err_pulse`.
- R8: Invalidate-all clears bit 27 of slots 1 to N-1 and never touches slot 0. It pulses `flush_pulse` in the next cycle only if at least one of those bits was set.
- R9: Invalidate-by-address looks up `inv_addr` with the rules of R2. On a hit it clears bit 27 of the matching slot and pulses `flush_pulse`. On a miss nothing changes and no pulse is raised.
- R10: Commands arriving in the same cycle are resolved by priority: invalidate-all, then invalidate-by-address, then write. A lower command is dropped without error.
- R11: `flush_pulse` follows only an invalidate command, and `err_pulse` follows only a write or a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_big_seg_en | input | 1 | Allows 1 TB entries to be written |
| lk_ea | input | 64 | Lookup effective address |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_slot | output | log2(N) | Winning slot number |
| lk_seg_word | output | 64 | Segment word of the winning slot |
| lk_virt_word | output | 64 | Descriptor word of the winning slot |
| wr_en | input | 1 | Write request |
| wr_sel_word | input | 64 | Slot field [11:0] and segment word to store |
| wr_virt_word | input | 64 | Descriptor word to store |
| rd_en | input | 1 | Read request |
| rd_virt_half | input | 1 | 0 reads the segment word, 1 reads the descriptor word |
| rd_idx | input | 12 | Slot index to read |
| rd_data | output | 64 | Registered read result |
| inv_all | input | 1 | Invalidate every slot except slot 0 |
| inv_addr_en | input | 1 | Invalidate the entry that `inv_addr` maps to |
| inv_addr | input | 64 | Address for invalidate-by-address |
| flush_pulse | output | 1 | One-cycle request to flush translation caches |
| err_pulse | output | 1 | One-cycle illegal-operation flag |

## Verification
A corrupted entry shows up at the ports in two ways. The lookup port reports it in the same cycle the entry is used. A read of that slot reports it one cycle after the request. The bench therefore pairs every table change with a full readback of both words of all slots, and with a sweep of lookups that crosses the segment boundaries.

Faults in the valid flag need their own checks. A flag stuck set or wrongly cleared surfaces as a wrong hit or a missing hit at the next lookup. It also surfaces as a `flush_pulse` that is present or absent one cycle after an invalidate. The bench compares that pulse against a flush expectation computed from its own copy of the table.

// File: rtl/slb_pkg.sv
`timescale 1ns/1ps
package slb_pkg;
  localparam int unsigned WORD_W     = 64;
  localparam int unsigned SLOT_FLD_W = 12;
  localparam int unsigned VALID_BIT  = 27;

  localparam logic [WORD_W-1:0] SEG_SMALL_MASK = 64'hFFFF_FFFF_F000_0000;
  localparam logic [WORD_W-1:0] SEG_LARGE_MASK = 64'hFFFF_FF00_0000_0000;
  localparam logic [WORD_W-1:0] VALID_MASK     = 64'h0000_0000_0800_0000;
  localparam logic [WORD_W-1:0] KEEP_MASK      = SEG_SMALL_MASK | VALID_MASK;

  typedef enum logic [1:0] {
    SZ_SMALL = 2'b00,
    SZ_LARGE = 2'b01
  } seg_size_e;

  function automatic logic [WORD_W-1:0] small_key(input logic [WORD_W-1:0] ea);
    return (ea & SEG_SMALL_MASK) | VALID_MASK;
  endfunction

  function automatic logic [WORD_W-1:0] large_key(input logic [WORD_W-1:0] ea);
    return (ea & SEG_LARGE_MASK) | VALID_MASK;
  endfunction
endpackage

// File: rtl/slb_match.sv
`timescale 1ns/1ps
module slb_match
  import slb_pkg::*;
#(
  parameter int unsigned N = 32,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [WORD_W-1:0] ea,
  input  logic [WORD_W-1:0] seg_arr  [N],
  input  logic [1:0]        size_arr [N],
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [WORD_W-1:0] k_small;
  logic [WORD_W-1:0] k_large;
  logic [N-1:0]      match;

  assign k_small = small_key(ea);
  assign k_large = large_key(ea);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = ((seg_arr[g] == k_small) && (size_arr[g] == SZ_SMALL)) ||
                      ((seg_arr[g] == k_large) && (size_arr[g] == SZ_LARGE));
  end

  // descending scan: the last assignment is the lowest matching slot
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/slb_wcheck.sv
`timescale 1ns/1ps
module slb_wcheck
  import slb_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic [SLOT_FLD_W-1:0] slot_fld,
  input  logic [1:0]            size_code,
  input  logic                  big_en,
  output logic                  ok
);
  localparam logic [SLOT_FLD_W-1:0] HI_MASK = ~SLOT_FLD_W'(N - 1);

  logic slot_ok;
  logic size_ok;

  assign slot_ok = (slot_fld & HI_MASK) == '0;
  assign size_ok = !size_code[1] && !(size_code[0] && !big_en);
  assign ok      = slot_ok && size_ok;
endmodule

// File: rtl/seg_lookaside_buf.sv
`timescale 1ns/1ps
module seg_lookaside_buf
  import slb_pkg::*;
#(
  parameter int unsigned N = 32,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_big_seg_en,
  input  logic [WORD_W-1:0]     lk_ea,
  output logic                  lk_hit,
  output logic [IDX_W-1:0]      lk_slot,
  output logic [WORD_W-1:0]     lk_seg_word,
  output logic [WORD_W-1:0]     lk_virt_word,
  input  logic                  wr_en,
  input  logic [WORD_W-1:0]     wr_sel_word,
  input  logic [WORD_W-1:0]     wr_virt_word,
  input  logic                  rd_en,
  input  logic                  rd_virt_half,
  input  logic [SLOT_FLD_W-1:0] rd_idx,
  output logic [WORD_W-1:0]     rd_data,
  input  logic                  inv_all,
  input  logic                  inv_addr_en,
  input  logic [WORD_W-1:0]     inv_addr,
  output logic                  flush_pulse,
  output logic                  err_pulse
);
  logic [WORD_W-1:0] seg_q  [N];
  logic [WORD_W-1:0] virt_q [N];
  logic [1:0]        size_v [N];

  for (genvar g = 0; g < N; g++) begin : g_size
    assign size_v[g] = virt_q[g][WORD_W-1:WORD_W-2];
  end

  logic             lk_hit_w;
  logic [IDX_W-1:0] lk_idx_w;
  logic             inv_hit;
  logic [IDX_W-1:0] inv_idx;
  logic             wr_ok;

  slb_match #(.N(N)) u_lk_match (
    .ea(lk_ea), .seg_arr(seg_q), .size_arr(size_v),
    .hit(lk_hit_w), .idx(lk_idx_w)
  );

  slb_match #(.N(N)) u_inv_match (
    .ea(inv_addr), .seg_arr(seg_q), .size_arr(size_v),
    .hit(inv_hit), .idx(inv_idx)
  );

  slb_wcheck #(.N(N)) u_wcheck (
    .slot_fld(wr_sel_word[SLOT_FLD_W-1:0]),
    .size_code(wr_virt_word[WORD_W-1:WORD_W-2]),
    .big_en(cfg_big_seg_en),
    .ok(wr_ok)
  );

  assign lk_hit       = lk_hit_w;
  assign lk_slot      = lk_hit_w ? lk_idx_w : '0;
  assign lk_seg_word  = lk_hit_w ? seg_q[lk_idx_w]  : '0;
  assign lk_virt_word = lk_hit_w ? virt_q[lk_idx_w] : '0;

  // any valid entry outside the protected slot 0
  logic upper_valid;
  always_comb begin
    upper_valid = 1'b0;
    for (int i = 1; i < N; i++) upper_valid = upper_valid | seg_q[i][VALID_BIT];
  end

  logic             wr_take;
  logic             wr_bad;
  logic             rd_ok;
  logic [IDX_W-1:0] wr_slot;
  logic [IDX_W-1:0] rd_slot;

  assign wr_take = wr_en && !inv_all && !inv_addr_en;
  assign wr_bad  = wr_take && !wr_ok;
  assign wr_slot = wr_sel_word[IDX_W-1:0];
  assign rd_ok   = rd_idx < SLOT_FLD_W'(N);
  assign rd_slot = rd_idx[IDX_W-1:0];

  logic [WORD_W-1:0] rd_data_q;
  logic              flush_q;
  logic              err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        seg_q[i]  <= '0;
        virt_q[i] <= '0;
      end
      rd_data_q <= '0;
      flush_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      flush_q <= (inv_all && upper_valid) || (!inv_all && inv_addr_en && inv_hit);
      err_q   <= wr_bad || (rd_en && !rd_ok);
      if (rd_en) begin
        rd_data_q <= !rd_ok ? '0 : (rd_virt_half ? virt_q[rd_slot] : seg_q[rd_slot]);
      end
      if (inv_all) begin
        for (int i = 1; i < N; i++) seg_q[i][VALID_BIT] <= 1'b0;
      end else if (inv_addr_en) begin
        if (inv_hit) seg_q[inv_idx][VALID_BIT] <= 1'b0;
      end else if (wr_en && wr_ok) begin
        seg_q[wr_slot]  <= wr_sel_word & KEEP_MASK;
        virt_q[wr_slot] <= wr_virt_word;
      end
    end
  end

  assign rd_data     = rd_data_q;
  assign flush_pulse = flush_q;
  assign err_pulse   = err_q;
endmodule

// File: rtl/slb_chk.sv
`timescale 1ns/1ps
module slb_chk
  import slb_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  inv_all,
  input logic                  inv_addr_en,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [SLOT_FLD_W-1:0] rd_idx,
  input logic [WORD_W-1:0]     rd_data,
  input logic                  lk_hit,
  input logic [WORD_W-1:0]     lk_seg_word,
  input logic [WORD_W-1:0]     lk_virt_word,
  input logic                  flush_pulse,
  input logic                  err_pulse
);
  a_r11_flush_cause: assert property (@(posedge clk) disable iff (rst)
    flush_pulse |-> $past(inv_all || inv_addr_en));

  a_r11_err_cause: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> $past(wr_en || rd_en));

  a_r7_oor_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rd_idx >= SLOT_FLD_W'(N))) |=> (err_pulse && (rd_data == '0)));

  a_r2_miss_zero: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> ((lk_seg_word == '0) && (lk_virt_word == '0)));

  a_r2_hit_valid: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_seg_word[VALID_BIT]);

  a_r6_legal_size: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> !lk_virt_word[WORD_W-1]);

  a_r10_write_dropped: assert property (@(posedge clk) disable iff (rst)
    ((inv_all || inv_addr_en) && !rd_en) |=> !err_pulse);
endmodule

bind seg_lookaside_buf slb_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .inv_all(inv_all), .inv_addr_en(inv_addr_en),
  .wr_en(wr_en), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
  .lk_hit(lk_hit), .lk_seg_word(lk_seg_word), .lk_virt_word(lk_virt_word),
  .flush_pulse(flush_pulse), .err_pulse(err_pulse)
);

// File: tb/seg_lookaside_buf_tb.sv
`timescale 1ns/1ps
module seg_lookaside_buf_tb;
  localparam int unsigned N  = 8;
  localparam int unsigned IW = 3;
  localparam logic [63:0] KEEP = 64'hFFFF_FFFF_F800_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_big_seg_en = 1'b0;
  logic [63:0] lk_ea = '0;
  logic        lk_hit;
  logic [IW-1:0] lk_slot;
  logic [63:0] lk_seg_word, lk_virt_word;
  logic        wr_en = 1'b0;
  logic [63:0] wr_sel_word = '0, wr_virt_word = '0;
  logic        rd_en = 1'b0, rd_virt_half = 1'b0;
  logic [11:0] rd_idx = '0;
  logic [63:0] rd_data;
  logic        inv_all = 1'b0, inv_addr_en = 1'b0;
  logic [63:0] inv_addr = '0;
  logic        flush_pulse, err_pulse;

  always #2.5 clk = ~clk;

  seg_lookaside_buf #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .cfg_big_seg_en(cfg_big_seg_en),
    .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_slot(lk_slot),
    .lk_seg_word(lk_seg_word), .lk_virt_word(lk_virt_word),
    .wr_en(wr_en), .wr_sel_word(wr_sel_word), .wr_virt_word(wr_virt_word),
    .rd_en(rd_en), .rd_virt_half(rd_virt_half), .rd_idx(rd_idx), .rd_data(rd_data),
    .inv_all(inv_all), .inv_addr_en(inv_addr_en), .inv_addr(inv_addr),
    .flush_pulse(flush_pulse), .err_pulse(err_pulse)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [63:0] m_seg  [N];
  logic [63:0] m_virt [N];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int mlook(input logic [63:0] ea);
    logic [63:0] ks, kl;
    ks = (ea & 64'hFFFF_FFFF_F000_0000) | 64'h0800_0000;
    kl = (ea & 64'hFFFF_FF00_0000_0000) | 64'h0800_0000;
    for (int i = 0; i < N; i++) begin
      if ((m_seg[i] == ks && m_virt[i][63:62] == 2'b00) ||
          (m_seg[i] == kl && m_virt[i][63:62] == 2'b01)) return i;
    end
    return -1;
  endfunction

  function automatic bit wr_legal(input logic [63:0] sw, input logic [63:0] vw);
    return ((sw[11:0] & ~12'(N - 1)) == 12'h0) && !vw[63] && !(vw[62] && !cfg_big_seg_en);
  endfunction

  task automatic lk_chk(input logic [63:0] ea, input string tag);
    int e;
    @(negedge clk);
    lk_ea = ea;
    #1;
    e = mlook(ea);
    if (e < 0) begin
      chk(!lk_hit, {tag, " miss flag"}, 64'(lk_hit), 64'd0);
      chk(lk_seg_word == '0 && lk_virt_word == '0, {tag, " miss zero"}, lk_seg_word, 64'd0);
    end else begin
      chk(lk_hit && lk_slot == IW'(e), {tag, " hit slot"}, 64'(lk_slot), 64'(e));
      chk(lk_seg_word == m_seg[e] && lk_virt_word == m_virt[e], {tag, " hit data"},
          lk_virt_word, m_virt[e]);
    end
  endtask

  task automatic rd_op(input logic [11:0] idx, input bit half, input logic [63:0] exp,
                       input bit exp_err, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = idx; rd_virt_half = half;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_data == exp, {tag, " read data"}, rd_data, exp);
    chk(err_pulse == exp_err, {tag, " read err"}, 64'(err_pulse), 64'(exp_err));
  endtask

  task automatic verify_all(input string tag);
    for (int i = 0; i < N; i++) begin
      rd_op(12'(i), 1'b0, m_seg[i], 1'b0, tag);
      rd_op(12'(i), 1'b1, m_virt[i], 1'b0, tag);
    end
  endtask

  task automatic wr_op(input logic [63:0] sw, input logic [63:0] vw, input string tag);
    bit ok;
    ok = wr_legal(sw, vw);
    @(negedge clk);
    wr_en = 1'b1; wr_sel_word = sw; wr_virt_word = vw;
    @(negedge clk);
    wr_en = 1'b0;
    chk(err_pulse == !ok, {tag, " write err"}, 64'(err_pulse), 64'(!ok));
    if (ok) begin
      m_seg[sw[IW-1:0]]  = sw & KEEP;
      m_virt[sw[IW-1:0]] = vw;
    end
  endtask

  task automatic inv_all_op(input string tag);
    bit exp_f;
    exp_f = 1'b0;
    for (int i = 1; i < N; i++) exp_f = exp_f | m_seg[i][27];
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    chk(flush_pulse == exp_f, {tag, " flush"}, 64'(flush_pulse), 64'(exp_f));
    for (int i = 1; i < N; i++) m_seg[i][27] = 1'b0;
  endtask

  task automatic inv_addr_op(input logic [63:0] ea, input string tag);
    int e;
    e = mlook(ea);
    @(negedge clk);
    inv_addr_en = 1'b1; inv_addr = ea;
    @(negedge clk);
    inv_addr_en = 1'b0;
    chk(flush_pulse == (e >= 0), {tag, " flush"}, 64'(flush_pulse), 64'(e >= 0));
    if (e >= 0) m_seg[e][27] = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_seg[i] = '0; m_virt[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!err_pulse && !flush_pulse, "R1 flags", {62'd0, err_pulse, flush_pulse}, 64'd0);
    lk_chk(64'h0, "R1");
    lk_chk(64'h0000_0000_1000_0000, "R1");
    verify_all("R1");

    // R4: fill all slots, junk in masked bits [26:12]
    for (int s = 0; s < N; s++)
      wr_op((64'(s + 1) << 28) | 64'h0800_0000 | (64'h5A5 << 12) | 64'(s),
            {2'b00, 62'h0ABC_DEF0_1234_5678} ^ 64'(s * 3), "R4");
    verify_all("R4");

    // R5: illegal slot fields
    wr_op(64'h1_0800_0008, 64'h1, "R5");
    wr_op(64'h1_0800_0801, 64'h2, "R5");
    wr_op(64'h1_0800_0010, 64'h3, "R5");
    verify_all("R5");

    // R6: size codes and large-segment enable
    wr_op(64'h9_0800_0001, 64'h8000_0000_0000_0000, "R6");
    wr_op(64'h9_0800_0001, 64'hC000_0000_0000_0000, "R6");
    wr_op(64'hABCD_EF00_0800_0007, 64'h4000_0000_0000_0077, "R6");
    verify_all("R6");
    cfg_big_seg_en = 1'b1;
    wr_op(64'hABCD_EF00_0800_0007, 64'h4000_0000_0000_0077, "R6");

    // R2: lookup sweep across segment boundaries
    for (int k = 0; k < 20; k++)
      lk_chk((64'(k) << 28) | ((64'(k) * 64'h1234567) & 64'hFFF_FFFF), "R2");
    lk_chk(64'hABCD_EF12_3456_789A, "R2");
    lk_chk(64'hABCD_EE12_3456_789A, "R2");

    // R3: overlapping entries
    wr_op(64'h2_0800_0004, 64'h0000_0000_0000_4444, "R3");
    wr_op(64'h0_0800_0002, 64'h4000_0000_0000_2222, "R3");
    for (int k = 0; k < 12; k++)
      lk_chk((64'(k) << 28) | 64'h0123_4567, "R3");

    // R10: write dropped under invalidate-by-address (miss)
    @(negedge clk);
    inv_addr_en = 1'b1; inv_addr = 64'hFFFF_0000_0000_0000;
    wr_en = 1'b1; wr_sel_word = 64'h7_0800_0006; wr_virt_word = 64'h66;
    @(negedge clk);
    inv_addr_en = 1'b0; wr_en = 1'b0;
    chk(!err_pulse && !flush_pulse, "R10 no err/flush", {62'd0, err_pulse, flush_pulse}, 64'd0);
    rd_op(12'd6, 1'b0, m_seg[6], 1'b0, "R10");
    rd_op(12'd6, 1'b1, m_virt[6], 1'b0, "R10");

    // R9: invalidate by address
    inv_addr_op(64'h0000_0000_2000_0040, "R9");
    lk_chk(64'h0000_0000_2000_0040, "R9");
    inv_addr_op(64'hFFFF_0000_0000_0000, "R9");
    inv_addr_op(64'hABCD_EF00_0000_0000, "R9");
    lk_chk(64'hABCD_EF00_0000_0000, "R9");
    verify_all("R9");

    // R8: invalidate all, slot 0 survives
    inv_all_op("R8");
    verify_all("R8");
    lk_chk(64'h0000_0000_1000_0000, "R8");
    inv_all_op("R8");

    // R7: out-of-range reads
    rd_op(12'd8, 1'b0, 64'd0, 1'b1, "R7");
    rd_op(12'hFFF, 1'b1, 64'd0, 1'b1, "R7");
    rd_op(12'd0, 1'b1, m_virt[0], 1'b0, "R7");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule